// File: doc/BRIEF.md
# UART Debug Console Bus Master

This block is a bus master for an attached 16550-style UART. It talks to the UART over a byte-wide register bus with a 3-bit address, separate read and write strobes and a ready input from the UART. After reset it computes a baud divisor from a requested line rate and runs a fixed nine-write configuration sequence. It then serves two client ports:
- a transmit byte stream with a valid/ready handshake;
- a receive request port that works either as a single poll or as a blocking wait.

Each transmitted character goes out only once the UART reports that its holding register is empty. A line feed is always followed by an automatically inserted carriage return. A receive request reads the line status first and reads the data register only when a byte is waiting. A configuration pulse, taken while the block is idle, latches a new requested rate and runs the whole sequence again.

Top module: `dbgcon_uart_master`

## Requirements
- R1: After reset, `tx_ready` and `rx_ready` stay low until the configuration sequence has finished. The sequence is nine writes in this exact order: offset 3 = 0x00, offset 1 = 0xFF, offset 1 = 0x00, offset 3 = 0x80, offset 0 = divisor low byte, offset 1 = divisor high byte, offset 3 = 0x03, offset 4 = 0x03, offset 2 = 0x07.
- R2: The divisor is the low 16 bits of 115200 divided by the requested rate, using integer division. A requested rate of 0 gives divisor 12. After reset the requested rate is the parameter `RESET_RATE`, which defaults to 0.
- R3: When `cfg_start` is high while the block is idle, `cfg_rate` is latched and the full sequence of R1 runs again. `tx_ready` is low from the next cycle until that sequence ends.
- R4: While a strobe (`bus_wr` or `bus_rd`) is high and `bus_ready` is low, the address, write data and strobes hold their values into the next cycle. `bus_wr` and `bus_rd` are never high together.
- R5: In the cycle after an access completes (strobe high with `bus_ready` high), both strobes are low.
- R6: For every transmitted byte the block reads offset 5 (line status) repeatedly until bit 5 (holding register empty) reads 1. It then writes the byte to offset 0.
- R7: After transmitting 0x0A, the block transmits 0x0D with the same poll-then-write procedure before it accepts another byte.
- R8: A non-blocking receive (`rx_wait` = 0) reads offset 5 exactly once. If bit 0 (data ready) is 0, the block finishes with `rx_hit` = 0 and performs no read of offset 0. If bit 0 is 1, it reads offset 0 and returns that byte on `rx_byte` with `rx_hit` = 1.
- R9: A blocking receive (`rx_wait` = 1) keeps reading offset 5 until bit 0 is 1. It then reads offset 0 and returns that byte with `rx_hit` = 1.
- R10: A transmit request has priority over a receive request. While `tx_valid` is high, `rx_ready` is low, so a waiting receive runs only after the character and any inserted carriage return have been sent.
- R11: `rx_done` is a single-cycle pulse that marks when `rx_hit` and `rx_byte` are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | Restart the configuration sequence (taken when idle) |
| cfg_rate | input | RATE_W | Requested line rate for the restart |
| tx_byte | input | 8 | Character to transmit |
| tx_valid | input | 1 | Transmit character is valid |
| tx_ready | output | 1 | Block accepts a transmit character |
| rx_valid | input | 1 | Receive request is valid |
| rx_wait | input | 1 | 1 = blocking receive, 0 = single poll |
| rx_ready | output | 1 | Block accepts the receive request |
| rx_done | output | 1 | Receive result valid (one-cycle pulse) |
| rx_hit | output | 1 | 1 = a byte was read, 0 = no data |
| rx_byte | output | 8 | Received byte |
| bus_addr | output | 3 | UART register offset |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data from the UART |
| bus_ready | input | 1 | UART completes the current access |

## Verification
A transmit request and a receive request can arrive in the same cycle. The bench provokes this by raising `tx_valid` carrying a line feed and `rx_valid` for a single poll on the same clock edge. It then checks three things:
- `rx_ready` stays low while `tx_ready` is high;
- the bus log shows the line feed, then the inserted carriage return, each behind its own status poll;
- only after those does the receive status read appear.

The same log-based comparison covers every configuration sweep and transmit sweep, across line-status delays and bus wait states.

// File: rtl/dbgcon_pkg.sv
package dbgcon_pkg;

    localparam int unsigned REG_AW = 3;
    localparam int unsigned DIV_BYTES_W = 16;

    localparam logic [REG_AW-1:0] OFS_DATA   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_ENABLE = 3'd1;
    localparam logic [REG_AW-1:0] OFS_FIFO   = 3'd2;
    localparam logic [REG_AW-1:0] OFS_LINE   = 3'd3;
    localparam logic [REG_AW-1:0] OFS_MODEM  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_STATUS = 3'd5;

    localparam int unsigned STAT_RXRDY = 0;
    localparam int unsigned STAT_TXEMP = 5;

    localparam logic [3:0] INIT_LAST = 4'd8;

    typedef enum logic [2:0] {
        S_DIVGO, S_DIVWAIT, S_INIT, S_IDLE,
        S_TXPOLL, S_TXPUT, S_RXPOLL, S_RXGET
    } ctl_state_e;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [7:0]        data;
    } reg_write_t;

    function automatic reg_write_t init_step(input logic [3:0] idx,
                                             input logic [DIV_BYTES_W-1:0] dv);
        reg_write_t w;
        case (idx)
            4'd0:    w = '{OFS_LINE,   8'h00};
            4'd1:    w = '{OFS_ENABLE, 8'hFF};
            4'd2:    w = '{OFS_ENABLE, 8'h00};
            4'd3:    w = '{OFS_LINE,   8'h80};
            4'd4:    w = '{OFS_DATA,   dv[7:0]};
            4'd5:    w = '{OFS_ENABLE, dv[15:8]};
            4'd6:    w = '{OFS_LINE,   8'h03};
            4'd7:    w = '{OFS_MODEM,  8'h03};
            default: w = '{OFS_FIFO,   8'h07};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/dbgcon_divider.sv
module dbgcon_divider #(
    parameter int unsigned DIVIDEND = 115200,
    parameter int unsigned DVS_W    = 17,
    parameter int unsigned OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [OUT_W-1:0] quotient
);
    localparam int unsigned DVD_W = $clog2(DIVIDEND + 1);
    localparam int unsigned RW    = DVS_W + 1;
    localparam int unsigned CW    = $clog2(DVD_W + 1);
    localparam logic [DVD_W-1:0] DVD = DVD_W'(DIVIDEND);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [RW-1:0]    rem;
        logic [DVD_W-1:0] quo;
        logic             done;
    } div_t;

    div_t r_q, r_d;
    logic [RW-1:0] shifted;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        shifted  = {r_q.rem[RW-2:0], r_q.quo[DVD_W-1]};
        if (start) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CW'(DVD_W);
            r_d.rem  = '0;
            r_d.quo  = DVD;
        end else if (r_q.busy) begin
            r_d.quo = {r_q.quo[DVD_W-2:0], 1'b0};
            if (shifted >= {1'b0, divisor}) begin
                r_d.rem    = shifted - {1'b0, divisor};
                r_d.quo[0] = 1'b1;
            end else begin
                r_d.rem = shifted;
            end
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done     = r_q.done;
    assign quotient = r_q.quo[OUT_W-1:0];

endmodule

// File: rtl/dbgcon_busport.sv
module dbgcon_busport
    import dbgcon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_wr,
    input  logic [REG_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              cmd_ready,
    output logic              cmd_done,
    output logic [7:0]        cmd_rdata,
    output logic [REG_AW-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready
);
    typedef enum logic [1:0] {P_IDLE, P_ACC, P_GAP} port_state_e;

    typedef struct packed {
        port_state_e       st;
        logic [REG_AW-1:0] addr;
        logic [7:0]        wdata;
        logic              wr;
        logic              rd;
    } port_t;

    port_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        unique case (p_q.st)
            P_IDLE: if (cmd_valid) begin
                p_d.st    = P_ACC;
                p_d.addr  = cmd_addr;
                p_d.wdata = cmd_wdata;
                p_d.wr    = cmd_wr;
                p_d.rd    = !cmd_wr;
            end
            P_ACC: if (bus_ready) begin
                p_d.st = P_GAP;
                p_d.wr = 1'b0;
                p_d.rd = 1'b0;
            end
            default: p_d.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{st: P_IDLE, default: '0};
        else        p_q <= p_d;
    end

    assign cmd_ready = (p_q.st == P_IDLE);
    assign cmd_done  = (p_q.st == P_ACC) && bus_ready;
    assign cmd_rdata = bus_rdata;
    assign bus_addr  = p_q.addr;
    assign bus_wdata = p_q.wdata;
    assign bus_wr    = p_q.wr;
    assign bus_rd    = p_q.rd;

endmodule

// File: rtl/dbgcon_uart_master.sv
module dbgcon_uart_master
    import dbgcon_pkg::*;
#(
    parameter int unsigned BASE_RATE  = 115200,
    parameter int unsigned RATE_W     = 17,
    parameter int unsigned RESET_RATE = 0,
    parameter int unsigned ZERO_DIV   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [7:0]        tx_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              rx_valid,
    input  logic              rx_wait,
    output logic              rx_ready,
    output logic              rx_done,
    output logic              rx_hit,
    output logic [7:0]        rx_byte,
    output logic [REG_AW-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready
);
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_CR = 8'h0D;

    typedef struct packed {
        ctl_state_e             st;
        logic [3:0]             step;
        logic [7:0]             ch;
        logic                   blocking;
        logic                   pend;
        logic [RATE_W-1:0]      rate;
        logic [DIV_BYTES_W-1:0] dv;
        logic                   div_go;
        logic                   done;
        logic                   hit;
        logic [7:0]             data;
    } ctl_t;

    ctl_t c_q, c_d;

    logic                   cmd_valid, cmd_wr, cmd_ready, cmd_done;
    logic [REG_AW-1:0]      cmd_addr;
    logic [7:0]             cmd_wdata, cmd_rdata;
    logic                   div_done;
    logic [DIV_BYTES_W-1:0] div_quo;
    reg_write_t             iw;

    dbgcon_divider #(
        .DIVIDEND (BASE_RATE),
        .DVS_W    (RATE_W),
        .OUT_W    (DIV_BYTES_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (c_q.div_go),
        .divisor  (c_q.rate),
        .done     (div_done),
        .quotient (div_quo)
    );

    dbgcon_busport u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_wr    (cmd_wr),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready),
        .cmd_done  (cmd_done),
        .cmd_rdata (cmd_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    always_comb begin
        c_d        = c_q;
        c_d.done   = 1'b0;
        c_d.div_go = 1'b0;
        cmd_valid  = 1'b0;
        cmd_wr     = 1'b0;
        cmd_addr   = OFS_STATUS;
        cmd_wdata  = 8'h00;
        tx_ready   = 1'b0;
        rx_ready   = 1'b0;
        iw         = init_step(c_q.step, c_q.dv);

        unique case (c_q.st)
            S_DIVGO: begin
                c_d.div_go = 1'b1;
                c_d.st     = S_DIVWAIT;
            end
            S_DIVWAIT: if (div_done) begin
                c_d.dv   = (c_q.rate == '0) ? DIV_BYTES_W'(ZERO_DIV) : div_quo;
                c_d.step = '0;
                c_d.st   = S_INIT;
            end
            S_INIT: begin
                cmd_valid = !c_q.pend;
                cmd_wr    = 1'b1;
                cmd_addr  = iw.addr;
                cmd_wdata = iw.data;
            end
            S_IDLE: begin
                tx_ready = !cfg_start;
                rx_ready = !cfg_start && !tx_valid;
                if (cfg_start) begin
                    c_d.rate = cfg_rate;
                    c_d.st   = S_DIVGO;
                end else if (tx_valid) begin
                    c_d.ch = tx_byte;
                    c_d.st = S_TXPOLL;
                end else if (rx_valid) begin
                    c_d.blocking = rx_wait;
                    c_d.st       = S_RXPOLL;
                end
            end
            S_TXPUT: begin
                cmd_valid = !c_q.pend;
                cmd_wr    = 1'b1;
                cmd_addr  = OFS_DATA;
                cmd_wdata = c_q.ch;
            end
            S_RXGET: begin
                cmd_valid = !c_q.pend;
                cmd_addr  = OFS_DATA;
            end
            default: cmd_valid = !c_q.pend;
        endcase

        if (cmd_valid && cmd_ready) c_d.pend = 1'b1;

        if (cmd_done) begin
            c_d.pend = 1'b0;
            unique case (c_q.st)
                S_INIT: begin
                    if (c_q.step == INIT_LAST) c_d.st = S_IDLE;
                    else                       c_d.step = c_q.step + 1'b1;
                end
                S_TXPOLL: if (cmd_rdata[STAT_TXEMP]) c_d.st = S_TXPUT;
                S_TXPUT: begin
                    if (c_q.ch == CH_LF) begin
                        c_d.ch = CH_CR;
                        c_d.st = S_TXPOLL;
                    end else begin
                        c_d.st = S_IDLE;
                    end
                end
                S_RXPOLL: begin
                    if (cmd_rdata[STAT_RXRDY]) begin
                        c_d.st = S_RXGET;
                    end else if (!c_q.blocking) begin
                        c_d.done = 1'b1;
                        c_d.hit  = 1'b0;
                        c_d.data = 8'h00;
                        c_d.st   = S_IDLE;
                    end
                end
                S_RXGET: begin
                    c_d.done = 1'b1;
                    c_d.hit  = 1'b1;
                    c_d.data = cmd_rdata;
                    c_d.st   = S_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: S_DIVGO, rate: RATE_W'(RESET_RATE), default: '0};
        else        c_q <= c_d;
    end

    assign rx_done = c_q.done;
    assign rx_hit  = c_q.hit;
    assign rx_byte = c_q.data;

endmodule

// File: rtl/dbgcon_uart_master_chk.sv
module dbgcon_uart_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_ready,
    input logic       rx_done,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_ready
);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !bus_ready) |=>
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr) && $stable(bus_rd)));

    assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_ready) |=> !(bus_wr || bus_rd));

    assert_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R6: the block only offers to take a new character when no access is running
    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !(bus_wr || bus_rd));

endmodule

bind dbgcon_uart_master dbgcon_uart_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_ready  (rx_ready),
    .rx_done   (rx_done),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_ready (bus_ready)
);

// File: tb/test_dbgcon_uart_master.sv
`timescale 1ns/1ps
module test_dbgcon_uart_master;
    localparam int RATE_W = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_start = 1'b0;
    logic [RATE_W-1:0] cfg_rate = '0;
    logic [7:0] tx_byte = 8'h00;
    logic tx_valid = 1'b0, tx_ready;
    logic rx_valid = 1'b0, rx_wait = 1'b0, rx_ready;
    logic rx_done, rx_hit;
    logic [7:0] rx_byte;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic bus_wr, bus_rd;
    logic bus_ready = 1'b0;

    always #10 clk = ~clk;

    dbgcon_uart_master i_dbgcon_uart_master (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_rate(cfg_rate),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_wait(rx_wait), .rx_ready(rx_ready),
        .rx_done(rx_done), .rx_hit(rx_hit), .rx_byte(rx_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    // UART register model
    int lat = 0, wcnt = 0, thre_delay = 0, lsr_reads = 0;
    int pushed = 0, popped = 0;
    logic [7:0] rx_char = 8'h00;
    logic [2:0] log_a [0:1023];
    logic [7:0] log_d [0:1023];
    logic       log_w [0:1023];
    int log_n = 0;
    int hold_bad = 0, gap_bad = 0, cyc = 0;
    logic prev_act = 1'b0, prev_done = 1'b0;
    logic [2:0] prev_a = '0;
    logic [7:0] prev_d = '0;
    logic prev_w = 1'b0, prev_r = 1'b0;

    always_comb begin
        if (bus_addr == 3'd5)
            bus_rdata = {1'b0, (lsr_reads >= thre_delay), (lsr_reads >= thre_delay),
                         4'b0000, (pushed != popped)};
        else if (bus_addr == 3'd0)
            bus_rdata = rx_char;
        else
            bus_rdata = 8'h00;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if ((bus_wr || bus_rd) && !bus_ready) begin
            if (wcnt >= lat) begin bus_ready <= 1'b1; wcnt <= 0; end
            else wcnt <= wcnt + 1;
        end else begin
            bus_ready <= 1'b0;
        end
        if (bus_ready && (bus_wr || bus_rd)) begin
            log_a[log_n] <= bus_addr;
            log_d[log_n] <= bus_wr ? bus_wdata : bus_rdata;
            log_w[log_n] <= bus_wr;
            log_n <= log_n + 1;
            if (bus_rd && bus_addr == 3'd5) lsr_reads <= lsr_reads + 1;
            if (bus_rd && bus_addr == 3'd0) popped <= popped + 1;
            if (bus_wr && bus_addr == 3'd0) lsr_reads <= 0;
        end
        if (rst_n) begin
            if (prev_act && !prev_done &&
                (bus_addr != prev_a || bus_wdata != prev_d || bus_wr != prev_w || bus_rd != prev_r))
                hold_bad <= hold_bad + 1;
            if (prev_act && prev_done && (bus_wr || bus_rd)) gap_bad <= gap_bad + 1;
        end
        prev_act  <= bus_wr || bus_rd;
        prev_done <= bus_ready;
        prev_a <= bus_addr; prev_d <= bus_wdata; prev_w <= bus_wr; prev_r <= bus_rd;
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic wait_idle(input string req);
        int t = 0;
        while (!tx_ready && t < 5000) begin @(negedge clk); t++; end
        chk(tx_ready, req, 0, 1);
    endtask

    function automatic logic [15:0] exp_div(input int r);
        return (r == 0) ? 16'd12 : 16'((115200 / r) & 32'hFFFF);
    endfunction

    task automatic check_init(input int mark, input int r, input string req);
        logic [15:0] dv = exp_div(r);
        logic [2:0] ea [9] = '{3'd3, 3'd1, 3'd1, 3'd3, 3'd0, 3'd1, 3'd3, 3'd4, 3'd2};
        logic [7:0] ed [9];
        ed = '{8'h00, 8'hFF, 8'h00, 8'h80, dv[7:0], dv[15:8], 8'h03, 8'h03, 8'h07};
        chk(log_n - mark == 9, {req, " init write count"}, log_n - mark, 9);
        for (int i = 0; i < 9; i++) begin
            bit ok = log_w[mark+i] && log_a[mark+i] == ea[i] && log_d[mark+i] == ed[i];
            chk(ok, $sformatf("%s init step %0d rate %0d", req, i, r),
                {log_w[mark+i], log_a[mark+i], log_d[mark+i]}, {1'b1, ea[i], ed[i]});
        end
    endtask

    task automatic restart(input int r);
        int mark;
        @(negedge clk);
        mark = log_n;
        cfg_rate = RATE_W'(r);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk(!tx_ready, "R3 tx_ready low after restart", tx_ready, 0);
        wait_idle("R3 restart completes");
        check_init(mark, r, "R2");
    endtask

    // expect (delay+1) status reads then a write of c, starting at idx
    task automatic expect_tx(inout int idx, input logic [7:0] c, input int d, input string req);
        for (int k = 0; k <= d; k++) begin
            chk(!log_w[idx] && log_a[idx] == 3'd5, {req, " status poll"},
                {log_w[idx], log_a[idx]}, {1'b0, 3'd5});
            idx++;
        end
        chk(log_w[idx] && log_a[idx] == 3'd0 && log_d[idx] == c, {req, " data write"},
            {log_w[idx], log_a[idx], log_d[idx]}, {1'b1, 3'd0, c});
        idx++;
    endtask

    task automatic send(input logic [7:0] c);
        int t = 0;
        @(negedge clk);
        tx_byte = c; tx_valid = 1'b1;
        #1;
        while (!tx_ready && t < 5000) begin @(negedge clk); t++; end
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic rx_start(input bit w);
        int t = 0;
        @(negedge clk);
        rx_wait = w; rx_valid = 1'b1;
        #1;
        while (!rx_ready && t < 5000) begin @(negedge clk); t++; end
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_wait_done(output bit got_hit, output logic [7:0] got);
        int t = 0;
        while (!rx_done && t < 5000) begin @(negedge clk); t++; end
        chk(rx_done, "R11 rx_done seen", rx_done, 1);
        got_hit = rx_hit; got = rx_byte;
        @(negedge clk);
        chk(!rx_done, "R11 rx_done single cycle", rx_done, 0);
    endtask

    initial begin
        logic [7:0] chars [5] = '{8'h41, 8'h0A, 8'h00, 8'hFF, 8'h7E};
        int rates [11] = '{0, 300, 1200, 2400, 9600, 19200, 38400, 57600, 115200, 1, 7};
        int idx, mark;
        bit h;
        logic [7:0] b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!tx_ready && !rx_ready, "R1 ready low after reset", {tx_ready, rx_ready}, 0);
        wait_idle("R1 init completes");
        check_init(0, 0, "R1");

        // configuration sweep over rates and wait states
        for (int i = 0; i < 11; i++) begin
            lat = i % 3;
            restart(rates[i]);
        end

        // transmit sweep: chars x status delays x wait states
        foreach (chars[ci]) for (int d = 0; d < 3; d++) for (int l = 0; l < 3; l++) begin
            lat = l; thre_delay = d;
            mark = log_n;
            send(chars[ci]);
            wait_idle("R6 tx returns idle");
            idx = mark;
            expect_tx(idx, chars[ci], d, "R6");
            if (chars[ci] == 8'h0A) expect_tx(idx, 8'h0D, d, "R7 inserted CR");
            chk(idx == log_n, "R7 no extra accesses", log_n - mark, idx - mark);
        end

        // simultaneous tx and rx request
        lat = 1; thre_delay = 0;
        @(negedge clk);
        mark = log_n;
        tx_byte = 8'h0A; tx_valid = 1'b1; rx_wait = 1'b0; rx_valid = 1'b1;
        #1;
        chk(tx_ready && !rx_ready, "R10 tx wins over rx", {tx_ready, rx_ready}, 2'b10);
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        begin
            int t = 0;
            while (!rx_ready && t < 5000) begin @(negedge clk); t++; end
        end
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_wait_done(h, b);
        idx = mark;
        expect_tx(idx, 8'h0A, 0, "R10 LF first");
        expect_tx(idx, 8'h0D, 0, "R10 CR before rx");
        chk(!log_w[idx] && log_a[idx] == 3'd5 && idx + 1 == log_n, "R10 rx poll after tx",
            log_n - mark, 5);
        chk(!h, "R8 no data hit", h, 0);

        // non-blocking receive, no data
        lat = 0;
        mark = log_n;
        rx_start(1'b0);
        rx_wait_done(h, b);
        chk(log_n - mark == 1 && log_a[mark] == 3'd5 && !log_w[mark],
            "R8 single status read, no data read", log_n - mark, 1);
        chk(!h, "R8 hit low when empty", h, 0);

        // non-blocking receive, data present
        rx_char = 8'h5A; pushed++;
        mark = log_n;
        rx_start(1'b0);
        rx_wait_done(h, b);
        chk(h && b == 8'h5A, "R8 byte returned", {h, b}, {1'b1, 8'h5A});
        chk(log_n - mark == 2 && log_a[mark] == 3'd5 && log_a[mark+1] == 3'd0,
            "R8 status then data read", log_n - mark, 2);

        // blocking receive
        for (int l = 0; l < 3; l++) begin
            bit early = 1'b0;
            lat = l;
            mark = log_n;
            rx_start(1'b1);
            repeat (40) begin @(negedge clk); if (rx_done) early = 1'b1; end
            chk(!early, "R9 blocking waits for data", early, 0);
            chk(log_n - mark >= 2, "R9 repeated status polls", log_n - mark, 2);
            rx_char = 8'hC3 + 8'(l); pushed++;
            rx_wait_done(h, b);
            chk(h && b == 8'hC3 + 8'(l), "R9 blocking byte", {h, b}, {1'b1, 8'hC3 + 8'(l)});
            chk(log_a[log_n-1] == 3'd0 && !log_w[log_n-1], "R9 data read last",
                log_a[log_n-1], 0);
        end

        repeat (4) @(negedge clk);
        chk(hold_bad == 0, "R4 bus held until ready", hold_bad, 0);
        chk(gap_bad == 0, "R5 idle cycle after access", gap_bad, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule